// File: doc/BRIEF.md
# Programmable Serial Clock Generator

This block produces the serial clock for a bit-serial shift engine, together with single-cycle strobes marking each rising and falling clock edge and a pulse when each bit ends. The shift engine holds a request line high for as long as it wants bits. The generator clocks one bit after another until the request drops, then parks the clock low.

The clock rate comes from a 16-bit divisor. Each half-period lasts (divisor + 1) prescaled ticks. A prescaled tick is either every base cycle or, by default, every fifth base cycle. Two optional modes change the shape of a bit:

- In three-phase mode, a bit is three half-periods long (low, high, low), so data can stay put across both edges. The bit rate is then two thirds of the nominal rate.
- In adaptive mode, the high part of every bit is held until a returned copy of the clock is seen high on a dedicated input. That input passes through a synchronizer first.

The engine configures the block with a byte stream of decoded command codes. A new configuration is picked up only when a bit starts.

Top module: `ser_clk_gen`

## Requirements
- R1: After reset, the clock output is low and all strobes and the bit-end pulse are low. The reset configuration is divisor 0, prescaler on (one tick per 5 base cycles), three-phase off and adaptive off.
- R2: In normal mode, a bit is a high half-period followed by a low half-period. Each half-period lasts (divisor+1)×5 base cycles with the prescaler on and (divisor+1) with it off. A bit starts on the clock edge that samples the request high.
- R3: Byte 0x86 followed by two further bytes loads the divisor, low byte first. Those two bytes are taken as data, never as commands.
- R4: Byte 0x8A switches the divide-by-5 prescaler off and byte 0x8B switches it back on.
- R5: Byte 0x8C enables three-phase mode, in which a bit is low, high, low with each phase one half-period long. Byte 0x8D returns to normal mode.
- R6: Byte 0x96 enables adaptive mode, in which the high phase does not end until the synchronized return-clock input is high. The clock falls on the third edge after that input rises. Byte 0x97 disables adaptive mode.
- R7: Divisor and mode changes take effect only at the start of the next bit. A bit in progress keeps its length.
- R8: The rising strobe is high exactly in the first cycle the clock is high, and the falling strobe exactly in the first cycle it is low after being high. Each bit has exactly one of each.
- R9: The bit-end pulse is high for one cycle, in the cycle after the last cycle of each bit. While idle, the clock stays low.
- R10: Any byte other than the seven listed codes, when it is not a divisor data byte, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock (nominally 60 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Command byte valid this cycle |
| cfg_byte | input | 8 | Command or divisor data byte |
| bit_go | input | 1 | Request for bits; sampled at each bit boundary |
| rtck_in | input | 1 | Returned clock for adaptive mode (asynchronous) |
| sclk_out | output | 1 | Serial clock level, idles low |
| rise_stb | output | 1 | One-cycle strobe on each rising clock edge |
| fall_stb | output | 1 | One-cycle strobe on each falling clock edge |
| bit_done | output | 1 | One-cycle pulse after each completed bit |

## Verification
The properties assume that the return-clock input is only raised while the clock is high, as a real loopback would do. They also assume that the request line is held steady between the clock edges of the base clock. The bench changes both inputs only on falling base-clock edges. In adaptive tests it raises the return clock only after it has seen the serial clock high, and lowers it again once the bit has finished. Command bytes are sent one per cycle, and the bench waits until the last byte has been taken before it requests the next bit, except in the test that sends bytes during a running bit on purpose.

// File: rtl/ser_clk_gen_pkg.sv
package ser_clk_gen_pkg;
  localparam int DIV_W = 16;

  localparam logic [7:0] OP_SET_DIV   = 8'h86;
  localparam logic [7:0] OP_PRE_OFF   = 8'h8A;
  localparam logic [7:0] OP_PRE_ON    = 8'h8B;
  localparam logic [7:0] OP_TRI_ON    = 8'h8C;
  localparam logic [7:0] OP_TRI_OFF   = 8'h8D;
  localparam logic [7:0] OP_ADAPT_ON  = 8'h96;
  localparam logic [7:0] OP_ADAPT_OFF = 8'h97;

  typedef enum logic [1:0] {DEC_OP, DEC_LO, DEC_HI} dec_state_t;
  typedef enum logic [1:0] {PH_IDLE, PH_A, PH_B, PH_C} phase_t;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             pre5;
    logic             three_ph;
    logic             adapt;
  } clk_cfg_t;

  // clock level driven during a phase
  function automatic logic level_of(phase_t ph, logic three_ph);
    return three_ph ? (ph == PH_B) : (ph == PH_A);
  endfunction

  // last phase of a bit
  function automatic logic is_final(phase_t ph, logic three_ph);
    return three_ph ? (ph == PH_C) : (ph == PH_B);
  endfunction

  function automatic phase_t succ(phase_t ph);
    case (ph)
      PH_A:    return PH_B;
      PH_B:    return PH_C;
      default: return PH_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/ser_clk_cmd_decode.sv
module ser_clk_cmd_decode
  import ser_clk_gen_pkg::*;
#(
  parameter logic [DIV_W-1:0] DIV_RESET = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  output clk_cfg_t   cfg
);
  dec_state_t st;
  logic [7:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= DEC_OP;
      lo_q         <= '0;
      cfg.div      <= DIV_RESET;
      cfg.pre5     <= 1'b1;
      cfg.three_ph <= 1'b0;
      cfg.adapt    <= 1'b0;
    end else if (byte_vld) begin
      case (st)
        DEC_OP: begin
          case (byte_in)
            OP_SET_DIV:   st           <= DEC_LO;
            OP_PRE_OFF:   cfg.pre5     <= 1'b0;
            OP_PRE_ON:    cfg.pre5     <= 1'b1;
            OP_TRI_ON:    cfg.three_ph <= 1'b1;
            OP_TRI_OFF:   cfg.three_ph <= 1'b0;
            OP_ADAPT_ON:  cfg.adapt    <= 1'b1;
            OP_ADAPT_OFF: cfg.adapt    <= 1'b0;
            default:      st           <= DEC_OP;
          endcase
        end
        DEC_LO: begin
          lo_q <= byte_in;
          st   <= DEC_HI;
        end
        default: begin
          cfg.div <= {byte_in, lo_q};
          st      <= DEC_OP;
        end
      endcase
    end
  end
endmodule

// File: rtl/ser_clk_prescale.sv
module ser_clk_prescale #(
  parameter int RATIO = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bypass,
  output logic tick
);
  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt;

  assign tick = bypass || (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr || tick) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ser_clk_sync.sv
module ser_clk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ser_clk_seq.sv
module ser_clk_seq
  import ser_clk_gen_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     go,
  input  clk_cfg_t cfg_next,
  input  logic     tick,
  input  logic     ack,
  output logic     pre_clr,
  output logic     pre_bypass,
  output logic     sclk,
  output logic     rise,
  output logic     fall,
  output logic     done,
  output logic     busy,
  output logic     bit_start,
  output clk_cfg_t cfg_act
);
  phase_t           phase, nxt_phase;
  logic [DIV_W-1:0] hcnt;
  logic             wait_q;
  logic             elapsed, cur_high, ack_ok, advance, bit_end, nxt_three, nxt_level;

  always_comb begin
    busy      = (phase != PH_IDLE);
    elapsed   = busy && tick && (hcnt == cfg_act.div);
    cur_high  = level_of(phase, cfg_act.three_ph);
    ack_ok    = !(cfg_act.adapt && cur_high) || ack;
    advance   = (elapsed || wait_q) && ack_ok;
    bit_end   = advance && is_final(phase, cfg_act.three_ph);
    bit_start = go && (!busy || bit_end);
    if (bit_start)    nxt_phase = PH_A;
    else if (bit_end) nxt_phase = PH_IDLE;
    else if (advance) nxt_phase = succ(phase);
    else              nxt_phase = phase;
    nxt_three  = bit_start ? cfg_next.three_ph : cfg_act.three_ph;
    nxt_level  = level_of(nxt_phase, nxt_three);
    pre_clr    = bit_start || advance;
    pre_bypass = !cfg_act.pre5;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase        <= PH_IDLE;
      hcnt         <= '0;
      wait_q       <= 1'b0;
      sclk         <= 1'b0;
      rise         <= 1'b0;
      fall         <= 1'b0;
      done         <= 1'b0;
      cfg_act.div  <= '0;
      cfg_act.pre5 <= 1'b1;
      cfg_act.three_ph <= 1'b0;
      cfg_act.adapt    <= 1'b0;
    end else begin
      phase  <= nxt_phase;
      sclk   <= nxt_level;
      rise   <= nxt_level && !sclk;
      fall   <= !nxt_level && sclk;
      done   <= bit_end;
      wait_q <= (elapsed || wait_q) && !advance;
      if (bit_start) cfg_act <= cfg_next;
      if (pre_clr)
        hcnt <= '0;
      else if (busy && tick && !elapsed && !wait_q)
        hcnt <= hcnt + 1'b1;
    end
  end
endmodule

// File: rtl/ser_clk_gen.sv
module ser_clk_gen
  import ser_clk_gen_pkg::*;
#(
  parameter int               PRE_RATIO   = 5,
  parameter int               SYNC_STAGES = 2,
  parameter logic [DIV_W-1:0] DIV_RESET   = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_valid,
  input  logic [7:0] cfg_byte,
  input  logic       bit_go,
  input  logic       rtck_in,
  output logic       sclk_out,
  output logic       rise_stb,
  output logic       fall_stb,
  output logic       bit_done
);
  clk_cfg_t cfg_next, cfg_act;
  logic     tick_w, pre_clr_w, pre_bypass_w, ack_w, busy_w, bit_start_w;
  logic [DIV_W-1:0] div_act_w;
  logic     adapt_act_w;

  ser_clk_cmd_decode #(.DIV_RESET(DIV_RESET)) u_dec (
    .clk(clk), .rst_n(rst_n), .byte_vld(cfg_valid), .byte_in(cfg_byte), .cfg(cfg_next)
  );

  ser_clk_prescale #(.RATIO(PRE_RATIO)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(pre_clr_w), .bypass(pre_bypass_w), .tick(tick_w)
  );

  ser_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rtck_in), .q(ack_w)
  );

  ser_clk_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go(bit_go), .cfg_next(cfg_next), .tick(tick_w),
    .ack(ack_w), .pre_clr(pre_clr_w), .pre_bypass(pre_bypass_w), .sclk(sclk_out),
    .rise(rise_stb), .fall(fall_stb), .done(bit_done), .busy(busy_w),
    .bit_start(bit_start_w), .cfg_act(cfg_act)
  );

  assign div_act_w   = cfg_act.div;
  assign adapt_act_w = cfg_act.adapt;
endmodule

// File: rtl/ser_clk_gen_chk.sv
module ser_clk_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sclk_out,
  input logic        rise_stb,
  input logic        fall_stb,
  input logic        bit_done,
  input logic        busy_w,
  input logic        bit_start_w,
  input logic        ack_w,
  input logic        adapt_act_w,
  input logic [15:0] div_act_w
);
  // R8
  rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (sclk_out && !$past(sclk_out)));
  // R8
  fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (!sclk_out && $past(sclk_out)));
  // R8
  edge_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_out != $past(sclk_out)) |-> (rise_stb || fall_stb));
  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> !sclk_out);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |=> !bit_done);
  // R7
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && $past(busy_w) && !$past(bit_start_w)) |-> $stable(div_act_w));
  // R6
  adapt_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_stb && $past(adapt_act_w) && $past(busy_w)) |-> $past(ack_w));
endmodule

bind ser_clk_gen ser_clk_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_out(sclk_out), .rise_stb(rise_stb),
  .fall_stb(fall_stb), .bit_done(bit_done), .busy_w(busy_w),
  .bit_start_w(bit_start_w), .ack_w(ack_w), .adapt_act_w(adapt_act_w),
  .div_act_w(div_act_w)
);

// File: tb/test_ser_clk_gen.sv
module test_ser_clk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_valid = 1'b0;
  logic [7:0] cfg_byte = '0;
  logic       bit_go = 1'b0;
  logic       rtck_in = 1'b0;
  logic       sclk_out, rise_stb, fall_stb, bit_done;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ser_clk_gen i_ser_clk_gen (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_byte(cfg_byte),
    .bit_go(bit_go), .rtck_in(rtck_in), .sclk_out(sclk_out), .rise_stb(rise_stb),
    .fall_stb(fall_stb), .bit_done(bit_done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    cfg_valid = 1'b1;
    cfg_byte  = b;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  // Run one bit and collect its shape
  task automatic one_bit(output int total, output int high, output int rises,
                         output int falls, output int first_lvl, output int bad_stb);
    bit first = 1'b1;
    total = 0; high = 0; rises = 0; falls = 0; first_lvl = 0; bad_stb = 0;
    @(negedge clk);
    bit_go = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (first) begin
        bit_go = 1'b0;
        first_lvl = sclk_out;
        first = 1'b0;
      end
      if (bit_done) break;
      total++;
      high  += sclk_out;
      rises += rise_stb;
      falls += fall_stb;
      if ((rise_stb && !sclk_out) || (fall_stb && sclk_out)) bad_stb++;
    end
  endtask

  task automatic expect_bit(input string tag, input int n_exp, input int h_exp,
                            input int lvl_exp);
    int t, h, r, f, l, b;
    one_bit(t, h, r, f, l, b);
    check(t == n_exp, {tag, " bit length"}, t, n_exp);
    check(h == h_exp, {tag, " high cycles"}, h, h_exp);
    check(r == 1 && f == 1 && b == 0, {tag, " R8 strobes"}, r * 10 + f, 11);
    check(l == lvl_exp, {tag, " first level"}, l, lvl_exp);
    check(sclk_out == 1'b0, {tag, " R9 idle low"}, sclk_out, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(!sclk_out && !rise_stb && !fall_stb && !bit_done, "R1 reset outputs",
          {sclk_out, rise_stb, fall_stb, bit_done}, 0);
    expect_bit("R1 R2 default", 10, 5, 1);
  endtask

  task automatic t_prescale();
    send(8'h8A);
    expect_bit("R4 prescaler off", 2, 1, 1);
    send(8'h86); send(8'h03); send(8'h00);
    expect_bit("R3 R2 div3", 8, 4, 1);
    send(8'h8B);
    expect_bit("R4 prescaler on", 40, 20, 1);
  endtask

  task automatic t_little_endian();
    send(8'h8A);
    send(8'h86); send(8'h8B); send(8'h00);
    expect_bit("R3 data byte not a command", 280, 140, 1);
    send(8'h86); send(8'h01); send(8'h02);
    expect_bit("R3 low byte first", 1028, 514, 1);
  endtask

  task automatic t_three_phase();
    send(8'h86); send(8'h01); send(8'h00);
    send(8'h8C);
    expect_bit("R5 three-phase", 6, 2, 0);
    send(8'h8D);
    expect_bit("R5 three-phase off", 4, 2, 1);
  endtask

  task automatic t_ignored();
    send(8'h00); send(8'hFF); send(8'h87); send(8'h8E);
    expect_bit("R10 unknown codes", 4, 2, 1);
  endtask

  task automatic t_mid_bit();
    int t, h, r, f, l, b;
    send(8'h86); send(8'h09); send(8'h00);
    fork
      one_bit(t, h, r, f, l, b);
      begin
        repeat (3) @(negedge clk);
        cfg_valid = 1'b1; cfg_byte = 8'h86;
        @(negedge clk); cfg_byte = 8'h01;
        @(negedge clk); cfg_byte = 8'h00;
        @(negedge clk); cfg_valid = 1'b0;
      end
    join
    check(t == 20, "R7 running bit keeps length", t, 20);
    expect_bit("R7 new divisor next bit", 4, 2, 1);
  endtask

  task automatic t_adaptive();
    int k;
    send(8'h86); send(8'h00); send(8'h00);
    send(8'h96);
    @(negedge clk);
    bit_go = 1'b1;
    @(negedge clk);
    bit_go = 1'b0;
    check(sclk_out == 1'b1, "R6 bit started high", sclk_out, 1);
    repeat (20) @(negedge clk);
    check(sclk_out == 1'b1 && !bit_done, "R6 held high without ack", sclk_out, 1);
    rtck_in = 1'b1;
    k = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      k++;
      if (!sclk_out) break;
    end
    check(k == 3, "R6 fall after ack", k, 3);
    @(negedge clk);
    check(bit_done == 1'b1, "R6 bit ends after low half", bit_done, 1);
    rtck_in = 1'b0;
    send(8'h97);
    expect_bit("R6 adaptive off", 2, 1, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_prescale();
    t_little_endian();
    t_three_phase();
    t_ignored();
    t_mid_bit();
    t_adaptive();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule